// File: doc/BRIEF.md
# Fault qualifier and diagnosis encoder for a dual low-side switch

This block takes the raw fault indications of two power channels and turns them into a latched 8-bit diagnosis word, an active-low fault flag and one live status bit per channel. Each channel reports at most one 2-bit fault code. Overload, open load or under-current, and short to ground each have to persist for a programmable number of clock ticks before they are accepted. Channel overtemperature and the die-level overtemperature warning skip that wait.

The serial interface block reads the diagnosis word and sends a one-cycle clear strobe once a valid command has finished. The clear empties the word and restarts every qualification timer. The status bits are meant for a parallel status output. Each one follows the channel's effective input level while that channel is healthy, and shows the inverted level while a qualified fault is present. A status bit does not hold a fault after the fault has gone.

Top module: `fdiag_encoder`

## Requirements
- R1: After reset `diag_word` is 8'hFF, `fault_n` is 1, and each `status` bit equals its `in_lvl` bit.
- R2: A non-thermal fault class is accepted only after it has been sampled on `FILT_TICKS` consecutive rising edges. The code is written on the edge that takes the last of those samples. A shorter run is never accepted, and any change of class restarts the count.
- R3: Channel codes are 11 for normal, 10 for overload or overtemperature, 01 for open load or under-current, and 00 for short to ground. Overload counts only while `ch_on` is 1. Short to ground counts only while `ch_on` is 0. Open load counts in both states. When several are present, the order of precedence is overtemperature, then overload, then short to ground, then open load.
- R4: The word layout is as follows. Bits 7:6 always read 1. Bits 5:4 hold the code of channel index 1 and bits 3:2 the code of channel index 0. Bit 1 is 0 once any channel overtemperature has been latched. Bit 0 is 0 once the die warning has been latched.
- R5: A channel overtemperature sampled on an edge writes code 10 and clears bit 1 on that same edge, with no qualification delay. The die warning clears bit 0 in the same way.
- R6: A newly accepted fault replaces the channel's earlier code. A latched code stays after its cause disappears.
- R7: `diag_clr` sampled high sets the word to 8'hFF and restarts all qualification counts. It takes precedence over a fault that would be accepted on the same edge.
- R8: `fault_n` is 0 exactly while the latched word differs from 8'hFF.
- R9: `status[i]` equals `in_lvl[i]` XOR (a qualified fault is currently held on channel i, or `otemp_raw[i]` is high). The status bit is not latched: one edge after the raw fault is removed, it returns to `in_lvl[i]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| diag_clr | input | 1 | One-cycle clear strobe from the serial interface |
| ovl_raw | input | 2 | Raw current-limit or overload indication per channel |
| open_raw | input | 2 | Raw open-load or under-current indication per channel |
| sgnd_raw | input | 2 | Raw short-to-ground indication per channel |
| otemp_raw | input | 2 | Raw channel overtemperature per channel |
| ic_warn_raw | input | 1 | Raw die overtemperature warning |
| ch_on | input | 2 | Channel currently driven on |
| in_lvl | input | 2 | Effective input level per channel |
| diag_word | output | 8 | Latched diagnosis word |
| fault_n | output | 1 | Active-low any-fault flag |
| status | output | 2 | Live per-channel status bits |

## Verification
Assertions check the following on every cycle: the qualification counter stays within its bound, an accepted fault is followed by a held qualification, overtemperature is written on the edge that samples it, the word does not change without a cause, a clear yields 8'hFF, and a thermal fault pulls the fault flag low and inverts status. Only the bench's scenarios can show the exact acceptance edge against runs one tick shorter, the precedence among simultaneous faults, the dependence on the on-state, a restart after a class change or a clear, and a status bit that releases once its fault has gone.

// File: rtl/fdiag_pkg.sv
package fdiag_pkg;
   typedef logic [1:0] code_t;
   localparam code_t CODE_NORMAL   = 2'b11;
   localparam code_t CODE_OVERLOAD = 2'b10;
   localparam code_t CODE_OPEN     = 2'b01;
   localparam code_t CODE_SHORTGND = 2'b00;
   localparam int    NUM_CH        = 2;
   localparam int    WORD_W        = 8;
endpackage

// File: rtl/fdiag_chan_filter.sv
module fdiag_chan_filter
   import fdiag_pkg::*;
#(
   parameter int FILT_TICKS = 16
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  clr,
   input  logic  ovl_raw,
   input  logic  open_raw,
   input  logic  sgnd_raw,
   input  logic  ch_on,
   output code_t hit_code,
   output logic  hit,
   output logic  qualified
);
   localparam int CNT_W = $clog2(FILT_TICKS + 1);
   localparam logic [CNT_W-1:0] LIM    = CNT_W'(FILT_TICKS);
   localparam logic [CNT_W-1:0] LIM_M1 = CNT_W'(FILT_TICKS - 1);

   code_t            cls;
   code_t            cls_q;
   logic [CNT_W-1:0] cnt;

   // precedence: overload (on) > short to ground (off) > open load
   always_comb begin
      if (ovl_raw && ch_on)        cls = CODE_OVERLOAD;
      else if (sgnd_raw && !ch_on) cls = CODE_SHORTGND;
      else if (open_raw)           cls = CODE_OPEN;
      else                         cls = CODE_NORMAL;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         cls_q <= CODE_NORMAL;
      end else if (clr) begin
         cnt   <= '0;
         cls_q <= CODE_NORMAL;
      end else begin
         cls_q <= cls;
         if (cls == CODE_NORMAL)  cnt <= '0;
         else if (cls != cls_q)   cnt <= CNT_W'(1);
         else if (cnt != LIM)     cnt <= cnt + CNT_W'(1);
      end
   end

   assign hit       = !clr && (cls != CODE_NORMAL) && (cls == cls_q) && (cnt == LIM_M1);
   assign hit_code  = cls;
   assign qualified = (cnt == LIM);

   assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= LIM);
   assert_hit_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> qualified);
   assert_qual_class_R2: assert property (@(posedge clk) disable iff (!rst_n)
      qualified |-> cls_q != CODE_NORMAL);
endmodule

// File: rtl/fdiag_reg.sv
module fdiag_reg
   import fdiag_pkg::*;
(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clr,
   input  logic [NUM_CH-1:0]   hit,
   input  code_t [NUM_CH-1:0]  hit_code,
   input  logic [NUM_CH-1:0]   ot_raw,
   input  logic                ic_warn_raw,
   output logic [WORD_W-1:0]   diag_word
);
   code_t [NUM_CH-1:0] code_q;
   logic               ot_flag_q;
   logic               warn_q;

   for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          code_q[g] <= CODE_NORMAL;
         else if (clr)        code_q[g] <= CODE_NORMAL;
         else if (ot_raw[g])  code_q[g] <= CODE_OVERLOAD;
         else if (hit[g])     code_q[g] <= hit_code[g];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ot_flag_q <= 1'b1;
         warn_q    <= 1'b1;
      end else if (clr) begin
         ot_flag_q <= 1'b1;
         warn_q    <= 1'b1;
      end else begin
         ot_flag_q <= ot_flag_q & ~(|ot_raw);
         warn_q    <= warn_q & ~ic_warn_raw;
      end
   end

   assign diag_word = {2'b11, code_q[1], code_q[0], ot_flag_q, warn_q};

   assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> diag_word == 8'hFF);
   assert_ot0_bypass_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && ot_raw[0]) |=> (diag_word[3:2] == CODE_OVERLOAD) && !diag_word[1]);
   assert_ot1_bypass_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && ot_raw[1]) |=> (diag_word[5:4] == CODE_OVERLOAD) && !diag_word[1]);
   assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && hit == '0 && ot_raw == '0 && !ic_warn_raw) |=> $stable(diag_word));
endmodule

// File: rtl/fdiag_status.sv
module fdiag_status
   import fdiag_pkg::*;
(
   input  logic [NUM_CH-1:0] in_lvl,
   input  logic [NUM_CH-1:0] qualified,
   input  logic [NUM_CH-1:0] ot_raw,
   output logic [NUM_CH-1:0] status
);
   for (genvar g = 0; g < NUM_CH; g++) begin : g_st
      assign status[g] = in_lvl[g] ^ (qualified[g] | ot_raw[g]);
   end
endmodule

// File: rtl/fdiag_encoder.sv
module fdiag_encoder
   import fdiag_pkg::*;
#(
   parameter int FILT_TICKS = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       diag_clr,
   input  logic [1:0] ovl_raw,
   input  logic [1:0] open_raw,
   input  logic [1:0] sgnd_raw,
   input  logic [1:0] otemp_raw,
   input  logic       ic_warn_raw,
   input  logic [1:0] ch_on,
   input  logic [1:0] in_lvl,
   output logic [7:0] diag_word,
   output logic       fault_n,
   output logic [1:0] status
);
   if (FILT_TICKS < 2) begin : g_bad_filt
      $error("FILT_TICKS must be at least 2");
   end
   if (NUM_CH != 2 || WORD_W != 8) begin : g_bad_layout
      $error("diagnosis word layout assumes two channels in eight bits");
   end

   logic  [NUM_CH-1:0] hit;
   code_t [NUM_CH-1:0] hit_code;
   logic  [NUM_CH-1:0] qualified;

   for (genvar g = 0; g < NUM_CH; g++) begin : g_filt
      fdiag_chan_filter #(.FILT_TICKS(FILT_TICKS)) u_filt (
         .clk       (clk),
         .rst_n     (rst_n),
         .clr       (diag_clr),
         .ovl_raw   (ovl_raw[g]),
         .open_raw  (open_raw[g]),
         .sgnd_raw  (sgnd_raw[g]),
         .ch_on     (ch_on[g]),
         .hit_code  (hit_code[g]),
         .hit       (hit[g]),
         .qualified (qualified[g])
      );
   end

   fdiag_reg u_reg (
      .clk         (clk),
      .rst_n       (rst_n),
      .clr         (diag_clr),
      .hit         (hit),
      .hit_code    (hit_code),
      .ot_raw      (otemp_raw),
      .ic_warn_raw (ic_warn_raw),
      .diag_word   (diag_word)
   );

   fdiag_status u_status (
      .in_lvl    (in_lvl),
      .qualified (qualified),
      .ot_raw    (otemp_raw),
      .status    (status)
   );

   // every bit of the word reads 1 only when nothing is latched
   assign fault_n = &diag_word;

   assert_fault_pin_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!diag_clr && (|otemp_raw || ic_warn_raw)) |=> !fault_n);
   assert_fault_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
      diag_clr |=> fault_n);
   assert_status_ot0_R9: assert property (@(posedge clk) disable iff (!rst_n)
      otemp_raw[0] |-> status[0] != in_lvl[0]);
   assert_status_ot1_R9: assert property (@(posedge clk) disable iff (!rst_n)
      otemp_raw[1] |-> status[1] != in_lvl[1]);
endmodule

// File: tb/fdiag_encoder_test.sv
module fdiag_encoder_test;
   localparam int F = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       diag_clr = 1'b0;
   logic [1:0] ovl_raw = '0, open_raw = '0, sgnd_raw = '0, otemp_raw = '0;
   logic       ic_warn_raw = 1'b0;
   logic [1:0] ch_on = '0, in_lvl = '0;
   logic [7:0] diag_word;
   logic       fault_n;
   logic [1:0] status;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   fdiag_encoder #(.FILT_TICKS(F)) uut (
      .clk(clk), .rst_n(rst_n), .diag_clr(diag_clr),
      .ovl_raw(ovl_raw), .open_raw(open_raw), .sgnd_raw(sgnd_raw),
      .otemp_raw(otemp_raw), .ic_warn_raw(ic_warn_raw),
      .ch_on(ch_on), .in_lvl(in_lvl),
      .diag_word(diag_word), .fault_n(fault_n), .status(status)
   );

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic logic [7:0] word_with(input int ch, input logic [1:0] code);
      logic [7:0] w = 8'hFF;
      w[2 + 2*ch +: 2] = code;
      return w;
   endfunction

   // R3 code per fault kind and on-state: 0 overload, 1 short to ground, 2 open load
   function automatic logic [1:0] kind_code(input int kind, input bit on);
      case (kind)
         0:       return on ? 2'b10 : 2'b11;
         1:       return on ? 2'b11 : 2'b00;
         default: return 2'b01;
      endcase
   endfunction

   task automatic clear_all();
      ovl_raw = '0; open_raw = '0; sgnd_raw = '0; otemp_raw = '0; ic_warn_raw = 1'b0;
      diag_clr = 1'b1;
      tick(1);
      diag_clr = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL R1 watchdog actual=hung expected=complete");
      finish_run();
   end

   initial begin
      in_lvl = 2'b10;
      tick(2);
      // R1 reset state
      chk("R1", "diag after reset", diag_word, 8'hFF);
      chk("R1", "fault_n after reset", {7'd0, fault_n}, 8'd1);
      chk("R1", "status after reset", {6'd0, status}, {6'd0, in_lvl});
      rst_n = 1'b1;
      tick(1);

      // R2 R3 R4 R9 sweep over channel, on-state, kind and run length
      for (int ch = 0; ch < 2; ch++) begin
         for (int on = 0; on < 2; on++) begin
            for (int kind = 0; kind < 3; kind++) begin
               for (int len = 1; len <= F; len++) begin
                  logic [1:0] code;
                  logic [7:0] exp_w;
                  bit         q;
                  clear_all();
                  ch_on = '0; in_lvl = '0;
                  ch_on[ch] = on[0]; in_lvl[ch] = on[0];
                  case (kind)
                     0: ovl_raw[ch] = 1'b1;
                     1: sgnd_raw[ch] = 1'b1;
                     default: open_raw[ch] = 1'b1;
                  endcase
                  tick(len);
                  code  = kind_code(kind, on[0]);
                  q     = (code != 2'b11) && (len >= F);
                  exp_w = q ? word_with(ch, code) : 8'hFF;
                  chk("R2", "diag after run", diag_word, exp_w);
                  chk("R8", "fault_n after run", {7'd0, fault_n}, {7'd0, exp_w == 8'hFF});
                  chk("R9", "status during fault", {7'd0, status[ch]}, {7'd0, on[0] ^ q});
                  ovl_raw = '0; sgnd_raw = '0; open_raw = '0;
                  tick(1);
                  chk("R9", "status released", {7'd0, status[ch]}, {7'd0, on[0]});
                  chk("R6", "diag sticky", diag_word, exp_w);
               end
            end
         end
      end

      // R3 precedence among simultaneous faults
      clear_all();
      ch_on = 2'b01; in_lvl = 2'b01;
      ovl_raw[0] = 1'b1; sgnd_raw[0] = 1'b1; open_raw[0] = 1'b1;
      tick(F);
      chk("R3", "overload wins when on", diag_word, word_with(0, 2'b10));
      clear_all();
      ch_on = 2'b00; in_lvl = 2'b00;
      ovl_raw[0] = 1'b1; sgnd_raw[0] = 1'b1; open_raw[0] = 1'b1;
      tick(F);
      chk("R3", "short to ground wins when off", diag_word, word_with(0, 2'b00));

      // R6 overwrite by a new fault
      clear_all();
      ch_on = 2'b10; in_lvl = 2'b10;
      open_raw[1] = 1'b1;
      tick(F);
      chk("R6", "first fault latched", diag_word, word_with(1, 2'b01));
      ovl_raw[1] = 1'b1;
      tick(F);
      chk("R6", "overwritten by overload", diag_word, word_with(1, 2'b10));
      ovl_raw = '0; open_raw = '0;
      tick(3);
      chk("R6", "overwrite persists", diag_word, word_with(1, 2'b10));

      // R2 class change restarts the count
      clear_all();
      ch_on = 2'b01; in_lvl = 2'b01;
      open_raw[0] = 1'b1;
      tick(F - 1);
      ovl_raw[0] = 1'b1;
      tick(F - 1);
      chk("R2", "no accept after class change", diag_word, 8'hFF);
      tick(1);
      chk("R2", "accepted after restarted count", diag_word, word_with(0, 2'b10));

      // R5 overtemperature bypass, R9 live status
      clear_all();
      ch_on = 2'b10; in_lvl = 2'b10;
      otemp_raw[1] = 1'b1;
      #1;
      chk("R9", "status inverts at once", {6'd0, status}, 8'h00);
      tick(1);
      chk("R5", "overtemp latched in one edge", diag_word, 8'hFD & word_with(1, 2'b10));
      otemp_raw = '0;
      tick(1);
      chk("R9", "status released after overtemp", {6'd0, status}, 8'h02);
      ic_warn_raw = 1'b1;
      tick(1);
      ic_warn_raw = 1'b0;
      chk("R4", "die warning bit0", diag_word, 8'hFC & word_with(1, 2'b10));
      chk("R8", "fault_n low", {7'd0, fault_n}, 8'd0);

      // R7 clear restarts timers while fault stays present
      clear_all();
      ch_on = 2'b00; in_lvl = 2'b00;
      open_raw[0] = 1'b1;
      tick(F);
      chk("R7", "latched before clear", diag_word, word_with(0, 2'b01));
      diag_clr = 1'b1;
      tick(1);
      diag_clr = 1'b0;
      chk("R7", "cleared", diag_word, 8'hFF);
      chk("R8", "fault_n released", {7'd0, fault_n}, 8'd1);
      tick(F - 1);
      chk("R7", "count restarted", diag_word, 8'hFF);
      tick(1);
      chk("R7", "relatched after full count", diag_word, word_with(0, 2'b01));

      // R7 clear beats acceptance on the same edge
      clear_all();
      open_raw[1] = 1'b1;
      tick(F - 1);
      diag_clr = 1'b1;
      tick(1);
      diag_clr = 1'b0;
      chk("R7", "clear wins over acceptance", diag_word, 8'hFF);
      clear_all();

      finish_run();
   end
endmodule